// File: doc/BRIEF.md
# Flash Program and Erase Command Controller

This block sits between a 32-bit register bus and an embedded flash macro. Software loads a target address, selects either word programming or page erasing with a mode bit in the control register, and then writes a data word. That data write is what launches the operation. The block hands the operation to the macro as a single start pulse, with the address, the data and a program/erase select held steady beside it. It waits for the macro's done pulse and reports a buffer flag and a busy flag in the control register.

Every modification is guarded by a byte-key handshake. The unlock machine has four states: LOCKED, ARMED, ONE and MULTI. LOCKED moves to ARMED on key 0xA5; any other key leaves it in LOCKED. ARMED moves to ONE on 0xF1 and to MULTI on 0xF2; any other key returns it to LOCKED. ONE returns to LOCKED when its operation completes, and also on any key write. MULTI returns to LOCKED on the relock code 0x5A, and also on any other key write.

The operation sequencer has three states: IDLE, LAUNCH and WAIT. IDLE moves to LAUNCH on an accepted data write. LAUNCH always moves to WAIT one cycle later. WAIT moves to IDLE when done is sampled high. A data write that arrives while the block is locked or busy is dropped and raises a sticky error flag.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every register reads 0, the key machine is LOCKED, and fl_start, fl_erase and fl_addr are 0.
- R2: Only the order 0xA5 followed by 0xF1 or 0xF2 unlocks the block. A wrong value or a wrong order leaves it locked, so the next data write is rejected.
- R3: With control bit 18 clear, an accepted write to 0xB0 raises fl_start for exactly one cycle, in the cycle after the write. In that cycle fl_erase is 0, fl_addr is the stored address and fl_wdata is the written word.
- R4: With control bit 18 set, an accepted write to 0xB0 raises fl_start with fl_erase 1. In that cycle fl_addr is the stored address with bits 10:0 cleared (2 KiB page).
- R5: Control bit 19 reads 1 from the cycle after an accepted write until the start pulse has been issued, and reads 0 otherwise.
- R6: Control bit 20 reads 1 from the cycle after an accepted write until the cycle after fl_done is sampled high.
- R7: After an unlock with 0xF1, the block relocks as soon as the one operation completes.
- R8: After an unlock with 0xF2, the block stays unlocked across several operations until a key write such as 0x5A relocks it.
- R9: A write to 0xB0 while locked or busy starts nothing and sets control bit 24. Writing 1 to bit 24 clears it.
- R10: Control bits 1:0, 16 and 18, address register 0xA0 (32 bits) and timing bit 6 at 0xD0 read back as written. Read-only and unused bits read 0, and registers 0xB0, 0xC0 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fl_start | output | 1 | One-cycle operation start to the macro |
| fl_erase | output | 1 | 1 = page erase, 0 = word program |
| fl_addr | output | 32 | Target address (page-aligned for erase) |
| fl_wdata | output | 32 | Word to program |
| fl_done | input | 1 | Macro completion pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit register offset, a 32-bit address and data path, and a 2 KiB page. With the 2 KiB page, an unaligned erase address such as 0x317FF must reach the macro as 0x31000. The behavioural flash stub answers each start after a fixed latency of three cycles. That latency leaves room for a second data write while WAIT is still active, which exercises the busy rejection. It also pins the busy window to exactly five observed cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [11:0] OFS_CTRL = 12'h000;
    localparam logic [11:0] OFS_ADDR = 12'h0A0;
    localparam logic [11:0] OFS_DATA = 12'h0B0;
    localparam logic [11:0] OFS_KEY  = 12'h0C0;
    localparam logic [11:0] OFS_TIM  = 12'h0D0;

    localparam int CB_SEQ   = 16;
    localparam int CB_ERASE = 18;
    localparam int CB_BUF   = 19;
    localparam int CB_BUSY  = 20;
    localparam int CB_ERR   = 24;
    localparam int TB_FAST  = 6;

    localparam logic [7:0] KEY_ARM    = 8'hA5;
    localparam logic [7:0] KEY_ONE    = 8'hF1;
    localparam logic [7:0] KEY_MULTI  = 8'hF2;
    localparam logic [7:0] KEY_RELOCK = 8'h5A;

    typedef enum logic [1:0] {
        LK_LOCKED,
        LK_ARMED,
        LK_ONE,
        LK_MULTI
    } lock_state_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_LAUNCH,
        OP_WAIT
    } op_state_t;

endpackage

// File: rtl/flash_unlock_fsm.sv
module flash_unlock_fsm
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    input  logic       op_done,
    output logic       unlocked
);

    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: begin
                if (key_wr && key_val == KEY_ARM) state_d = LK_ARMED;
            end
            LK_ARMED: begin
                if (key_wr) begin
                    if (key_val == KEY_ONE)        state_d = LK_ONE;
                    else if (key_val == KEY_MULTI) state_d = LK_MULTI;
                    else                           state_d = LK_LOCKED;
                end
            end
            LK_ONE: begin
                if (key_wr || op_done) state_d = LK_LOCKED;
            end
            LK_MULTI: begin
                // KEY_RELOCK is the documented code; any key write relocks
                if (key_wr) state_d = LK_LOCKED;
            end
            default: state_d = LK_LOCKED;
        endcase
    end

    always_comb begin
        unlocked = (state_q == LK_ONE) || (state_q == LK_MULTI);
    end

    assert_single_relock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ONE && op_done) |=> (state_q == LK_LOCKED));

    assert_arm_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_LOCKED) |=> (state_q != LK_ONE && state_q != LK_MULTI));

    assert_multi_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_MULTI && !key_wr) |=> (state_q == LK_MULTI));

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int PAGE_LSB = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              fl_done,
    output logic              fl_start,
    output logic              fl_erase,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              buf_full,
    output logic              busy,
    output logic              op_done
);

    op_state_t state_q, state_d;
    logic [ADDR_W-1:0] page_base;

    always_comb begin
        page_base = {req_addr[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= OP_IDLE;
            fl_erase <= 1'b0;
            fl_addr  <= '0;
            fl_wdata <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == OP_IDLE && req) begin
                fl_erase <= req_erase;
                fl_addr  <= req_erase ? page_base : req_addr;
                fl_wdata <= req_data;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OP_IDLE:   if (req) state_d = OP_LAUNCH;
            OP_LAUNCH: state_d = OP_WAIT;
            OP_WAIT:   if (fl_done) state_d = OP_IDLE;
            default:   state_d = OP_IDLE;
        endcase
    end

    always_comb begin
        fl_start = (state_q == OP_LAUNCH);
        buf_full = (state_q == OP_LAUNCH);
        busy     = (state_q != OP_IDLE);
        op_done  = (state_q == OP_WAIT) && fl_done;
    end

    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start |=> !fl_start);

    assert_erase_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_start && fl_erase) |-> (fl_addr[PAGE_LSB-1:0] == '0));

    assert_busy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fl_start && fl_done) |=> !busy);

    assert_buf_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> busy);

    assert_req_launches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> fl_start);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int BUS_AW     = 12,
    parameter int BUS_DW     = 32,
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              fl_start,
    output logic              fl_erase,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [BUS_DW-1:0] fl_wdata,
    input  logic              fl_done
);

    localparam int PAGE_LSB = $clog2(PAGE_BYTES);

    logic [1:0]        speed_q;
    logic              seq_q;
    logic              erase_q;
    logic              err_q;
    logic              fast_q;
    logic [ADDR_W-1:0] tgt_addr_q;

    logic ctrl_wr, addr_wr, data_wr, key_wr, tim_wr;
    logic accept, reject;
    logic unlocked, busy, buf_full, op_done;

    always_comb begin
        ctrl_wr = bus_wen && (bus_addr == BUS_AW'(OFS_CTRL));
        addr_wr = bus_wen && (bus_addr == BUS_AW'(OFS_ADDR));
        data_wr = bus_wen && (bus_addr == BUS_AW'(OFS_DATA));
        key_wr  = bus_wen && (bus_addr == BUS_AW'(OFS_KEY));
        tim_wr  = bus_wen && (bus_addr == BUS_AW'(OFS_TIM));
        accept  = data_wr && unlocked && !busy;
        reject  = data_wr && !accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_q    <= '0;
            seq_q      <= 1'b0;
            erase_q    <= 1'b0;
            err_q      <= 1'b0;
            fast_q     <= 1'b0;
            tgt_addr_q <= '0;
        end else begin
            if (ctrl_wr) begin
                speed_q <= bus_wdata[1:0];
                seq_q   <= bus_wdata[CB_SEQ];
                erase_q <= bus_wdata[CB_ERASE];
            end
            if (reject)                          err_q <= 1'b1;
            else if (ctrl_wr && bus_wdata[CB_ERR]) err_q <= 1'b0;
            if (tim_wr)  fast_q     <= bus_wdata[TB_FAST];
            if (addr_wr) tgt_addr_q <= bus_wdata[ADDR_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BUS_AW'(OFS_CTRL)) begin
            bus_rdata[1:0]      = speed_q;
            bus_rdata[CB_SEQ]   = seq_q;
            bus_rdata[CB_ERASE] = erase_q;
            bus_rdata[CB_BUF]   = buf_full;
            bus_rdata[CB_BUSY]  = busy;
            bus_rdata[CB_ERR]   = err_q;
        end else if (bus_addr == BUS_AW'(OFS_ADDR)) begin
            bus_rdata = BUS_DW'(tgt_addr_q);
        end else if (bus_addr == BUS_AW'(OFS_TIM)) begin
            bus_rdata[TB_FAST] = fast_q;
        end
    end

    flash_unlock_fsm u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_val  (bus_wdata[7:0]),
        .op_done  (op_done),
        .unlocked (unlocked)
    );

    flash_op_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (BUS_DW),
        .PAGE_LSB (PAGE_LSB)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (accept),
        .req_erase (erase_q),
        .req_addr  (tgt_addr_q),
        .req_data  (bus_wdata),
        .fl_done   (fl_done),
        .fl_start  (fl_start),
        .fl_erase  (fl_erase),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .buf_full  (buf_full),
        .busy      (busy),
        .op_done   (op_done)
    );

    assert_reject_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> err_q);

    assert_no_start_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !unlocked && !busy) |=> !fl_start);

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
    import flash_cmd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fl_start, fl_erase;
    logic [31:0] fl_addr, fl_wdata;
    logic        fl_done = 1'b0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_start(fl_start),
        .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_done(fl_done)
    );

    // behavioural flash stub: done pulse a fixed latency after start
    int          n_start = 0;
    logic [31:0] cap_data = '0;
    logic [2:0]  lat_cnt = '0;
    always @(posedge clk) begin
        if (fl_start) begin
            n_start  <= n_start + 1;
            cap_data <= fl_wdata;
            lat_cnt  <= 3'd3;
        end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
        end
        fl_done <= (lat_cnt == 3'd1);
    end

    typedef struct packed {
        logic        rd;
        logic [11:0] a;
        logic [31:0] v;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 12'h000, 32'h0000_0000, 8'd1},   // R1 control
        '{1'b1, 12'h0A0, 32'h0000_0000, 8'd1},   // R1 address
        '{1'b1, 12'h0B0, 32'h0000_0000, 8'd1},   // R1 data
        '{1'b1, 12'h0C0, 32'h0000_0000, 8'd1},   // R1 key
        '{1'b1, 12'h0D0, 32'h0000_0000, 8'd1},   // R1 timing
        '{1'b0, 12'h000, 32'hFFFF_FFFF, 8'd10},  // R10
        '{1'b1, 12'h000, 32'h0005_0003, 8'd10},
        '{1'b0, 12'h0D0, 32'hFFFF_FFFF, 8'd10},
        '{1'b1, 12'h0D0, 32'h0000_0040, 8'd10},
        '{1'b0, 12'h0A0, 32'h1234_5678, 8'd10},
        '{1'b1, 12'h0A0, 32'h1234_5678, 8'd10},
        '{1'b0, 12'h000, 32'h0001_0002, 8'd10},
        '{1'b1, 12'h000, 32'h0001_0002, 8'd10},
        '{1'b1, 12'h010, 32'h0000_0000, 8'd10},
        '{1'b0, 12'h0B0, 32'h0000_BEEF, 8'd9},   // R9 locked write
        '{1'b1, 12'h000, 32'h0101_0002, 8'd9},
        '{1'b0, 12'h000, 32'h0100_0000, 8'd9},   // R9 write-1 clear
        '{1'b1, 12'h000, 32'h0000_0000, 8'd9},
        '{1'b1, 12'h0B0, 32'h0000_0000, 8'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] r;
        cyc = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cyc++;
            peek(OFS_CTRL, r);
            if (!r[CB_BUSY]) break;
        end
    endtask

    task automatic clear_err();
        wr(OFS_CTRL, 32'h0100_0000);
    endtask

    logic [31:0] r;
    int cyc, s0;

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 macro side idle after reset
        check("R1 fl_start", {31'd0, fl_start}, 32'd0);
        check("R1 fl_erase", {31'd0, fl_erase}, 32'd0);
        check("R1 fl_addr", fl_addr, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].rd) begin
                @(negedge clk);
                peek(TBL[i].a, r);
                check($sformatf("R%0d vec%0d", TBL[i].req, i), r, TBL[i].v);
            end else begin
                wr(TBL[i].a, TBL[i].v);
            end
        end
        check("R9 no start while locked", n_start, 0);

        // R2: wrong orders keep the block locked
        wr(OFS_CTRL, 32'h0);
        wr(OFS_KEY, KEY_ONE);
        wr(OFS_DATA, 32'h1);
        peek(OFS_CTRL, r);
        check("R2 F1 without A5", r[CB_ERR], 1'b1);
        clear_err();
        wr(OFS_KEY, KEY_ARM); wr(OFS_KEY, 32'h33); wr(OFS_KEY, KEY_MULTI);
        wr(OFS_DATA, 32'h2);
        peek(OFS_CTRL, r);
        check("R2 bad second key", r[CB_ERR], 1'b1);
        clear_err();
        wr(OFS_KEY, KEY_ARM); wr(OFS_KEY, KEY_ARM); wr(OFS_KEY, KEY_ONE);
        wr(OFS_DATA, 32'h3);
        peek(OFS_CTRL, r);
        check("R2 repeated A5", r[CB_ERR], 1'b1);
        check("R2 no start", n_start, 0);
        clear_err();

        // R3 program in single-unlock mode
        wr(OFS_KEY, KEY_ARM); wr(OFS_KEY, KEY_ONE);
        wr(OFS_ADDR, 32'h0000_1A3C);
        wr(OFS_DATA, 32'hCAFE_F00D);
        check("R3 start", {31'd0, fl_start}, 32'd1);
        check("R3 select", {31'd0, fl_erase}, 32'd0);
        check("R3 addr", fl_addr, 32'h0000_1A3C);
        check("R3 data", fl_wdata, 32'hCAFE_F00D);
        peek(OFS_CTRL, r);
        check("R5 buffer full", r[CB_BUF], 1'b1);
        check("R6 busy set", r[CB_BUSY], 1'b1);
        @(negedge clk);
        check("R3 single pulse", {31'd0, fl_start}, 32'd0);
        peek(OFS_CTRL, r);
        check("R5 buffer empty", r[CB_BUF], 1'b0);
        check("R6 busy held", r[CB_BUSY], 1'b1);
        wait_idle(cyc);
        check("R6 busy window", cyc, 4);
        check("R3 stub count", n_start, 1);
        check("R3 stub data", cap_data, 32'hCAFE_F00D);

        // R7 relock after one operation
        wr(OFS_DATA, 32'h5555_0000);
        peek(OFS_CTRL, r);
        check("R7 relocked", r[CB_ERR], 1'b1);
        check("R7 no start", n_start, 1);
        clear_err();

        // R4 erase in multi-unlock mode
        wr(OFS_KEY, KEY_ARM); wr(OFS_KEY, KEY_MULTI);
        wr(OFS_CTRL, 32'h0004_0000);
        wr(OFS_ADDR, 32'h0003_17FF);
        wr(OFS_DATA, 32'hFFFF_FFFF);
        check("R4 erase select", {31'd0, fl_erase}, 32'd1);
        check("R4 page address", fl_addr, 32'h0003_1000);
        wait_idle(cyc);

        // R9 busy rejection, R8 stays unlocked
        wr(OFS_CTRL, 32'h0);
        wr(OFS_ADDR, 32'h0000_0040);
        wr(OFS_DATA, 32'h0000_0011);
        wr(OFS_DATA, 32'h0000_0022);
        peek(OFS_CTRL, r);
        check("R9 busy reject flag", r[CB_ERR], 1'b1);
        wait_idle(cyc);
        check("R9 one start only", n_start, 3);
        check("R9 first word kept", cap_data, 32'h0000_0011);
        clear_err();
        wr(OFS_DATA, 32'h0000_0033);
        wait_idle(cyc);
        check("R8 still unlocked", n_start, 4);
        peek(OFS_CTRL, r);
        check("R9 flag cleared", r[CB_ERR], 1'b0);
        wr(OFS_KEY, KEY_RELOCK);
        s0 = n_start;
        wr(OFS_DATA, 32'h0000_0044);
        repeat (2) @(negedge clk);
        peek(OFS_CTRL, r);
        check("R8 relock code", r[CB_ERR], 1'b1);
        check("R8 no start after relock", n_start, s0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule